// File: doc/BRIEF.md
# Dual-Rail Minterm Complex Gate

This block is a single k-input complex logic node for delay-insensitive dual-rail logic. Each logical input and the one logical output travel on a pair of wires, a true rail and a false rail. The node computes any Boolean function of up to k variables. The function is chosen by a truth-table parameter, much as a lookup table in a programmable fabric is configured, so one design covers every k-input function.

Internally the node has two levels. The first level holds one Muller C-element per input minterm, 2^k in all. Each element watches, for every input, the single rail that matches its minterm's bit value. The second level ORs the element outputs onto the two output rails. Elements whose minterm maps to 1 feed the true rail, and those that map to 0 feed the false rail. The node follows a four-phase, return-to-spacer protocol. Its output becomes valid only after every input is valid, and it goes back to the spacer only after every input has returned there, so no separate completion detector is needed.

The C-elements are modelled as state elements that update on a sampling clock, with an asynchronous active-high reset. The node also raises a flag whenever a forbidden rail pair appears on any input or on the output.

Top module: `dims_cgate`

## Requirements
- R1: Each pair is coded as true=1,false=0 for logic 1, true=0,false=1 for logic 0, 0/0 for the spacer, and 1/1 as forbidden. The function index has bit i equal to the logical value of input i.
- R2: While `rst` is high, every minterm element is cleared at once, without waiting for a clock, and the output pair is the spacer 0/0.
- R3: Starting from an all-spacer state, the output pair stays 0/0 as long as at least one input pair is still the spacer.
- R4: One clock edge after the last input becomes valid, with all inputs legal, `out_t` equals `TT[index]` and `out_f` is its complement.
- R5: During the return phase, the output keeps its valid value while at least one input pair is still valid.
- R6: One clock edge after every input pair is back at the spacer, the output pair is 0/0.
- R7: `err` is high in the same cycle whenever any input pair or the output pair is 1/1, and low otherwise.
- R8: Any function of K inputs is realised: bit m of the 2^K-bit parameter `TT` gives the output for index m, for every K from 1 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the C-element state |
| rst | input | 1 | Asynchronous active-high reset, clears all C-elements |
| in_t | input | K | True rails of the K inputs |
| in_f | input | K | False rails of the K inputs |
| out_t | output | 1 | True rail of the result |
| out_f | output | 1 | False rail of the result |
| err | output | 1 | Forbidden 1/1 code seen on an input or output pair |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the arrival of the last valid input and the output leaving the spacer. The second pair is the departure of the last valid input and the output returning to the spacer. The sweep drives every input index and raises and drops the inputs in both ascending and descending order. After each single rail change it checks that the output has not moved early, and that it moves exactly one edge after the final change. A forbidden input code is then injected while the other inputs are valid, so that an error on an input and an error on the output occur together. The bench checks that the flag rises, and that an asynchronous reset clears the output at once.

// File: rtl/dims_pkg.sv
package dims_pkg;

    typedef struct packed {
        logic t;
        logic f;
    } dr_t;

    typedef enum logic [1:0] {
        DR_NULL = 2'b00,
        DR_ZERO = 2'b01,
        DR_ONE  = 2'b10,
        DR_BAD  = 2'b11
    } dr_code_e;

    function automatic dr_code_e dr_code(dr_t p);
        return dr_code_e'({p.t, p.f});
    endfunction

    function automatic logic dr_is_bad(dr_t p);
        return dr_code(p) == DR_BAD;
    endfunction

    function automatic logic dr_pick(dr_t p, logic want_one);
        return want_one ? p.t : p.f;
    endfunction

endpackage

// File: rtl/dims_celem.sv
module dims_celem #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a,
    output logic         y
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            y <= 1'b0;
        end else if (&a) begin
            y <= 1'b1;
        end else if (~|a) begin
            y <= 1'b0;
        end
    end
endmodule

// File: rtl/dims_minterm_bank.sv
module dims_minterm_bank
    import dims_pkg::*;
#(
    parameter int K  = 3,
    localparam int NM = 1 << K
) (
    input  logic              clk,
    input  logic              rst,
    input  dr_t [K-1:0]       ins,
    output logic [NM-1:0]     hit
);
    for (genvar m = 0; m < NM; m++) begin : g_term
        logic [K-1:0] sel;
        for (genvar i = 0; i < K; i++) begin : g_rail
            localparam logic WANT = ((m >> i) & 1) != 0;
            assign sel[i] = dr_pick(ins[i], WANT);
        end
        dims_celem #(.N(K)) u_celem (
            .clk (clk),
            .rst (rst),
            .a   (sel),
            .y   (hit[m])
        );
    end
endmodule

// File: rtl/dims_rail_or.sv
module dims_rail_or #(
    parameter int          NM = 8,
    parameter logic [NM-1:0] TT = '0
) (
    input  logic [NM-1:0] hit,
    output logic          rail_t,
    output logic          rail_f
);
    assign rail_t = |(hit & TT);
    assign rail_f = |(hit & ~TT);
endmodule

// File: rtl/dims_code_check.sv
module dims_code_check
    import dims_pkg::*;
#(
    parameter int K = 3
) (
    input  dr_t [K-1:0] ins,
    input  dr_t         outp,
    output logic        err
);
    logic [K-1:0] bad_in;
    for (genvar i = 0; i < K; i++) begin : g_bad
        assign bad_in[i] = dr_is_bad(ins[i]);
    end
    assign err = (|bad_in) | dr_is_bad(outp);
endmodule

// File: rtl/dims_cgate.sv
module dims_cgate
    import dims_pkg::*;
#(
    parameter int               K  = 3,
    parameter logic [(1<<K)-1:0] TT = 8'hE8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [K-1:0] in_t,
    input  logic [K-1:0] in_f,
    output logic         out_t,
    output logic         out_f,
    output logic         err
);
    localparam int NM = 1 << K;

    dr_t [K-1:0]   ins;
    dr_t           outp;
    logic [NM-1:0] hit;

    for (genvar i = 0; i < K; i++) begin : g_pack
        assign ins[i].t = in_t[i];
        assign ins[i].f = in_f[i];
    end

    dims_minterm_bank #(.K(K)) u_bank (
        .clk (clk),
        .rst (rst),
        .ins (ins),
        .hit (hit)
    );

    dims_rail_or #(.NM(NM), .TT(TT)) u_or (
        .hit    (hit),
        .rail_t (outp.t),
        .rail_f (outp.f)
    );

    dims_code_check #(.K(K)) u_chk_code (
        .ins  (ins),
        .outp (outp),
        .err  (err)
    );

    assign out_t = outp.t;
    assign out_f = outp.f;
endmodule

// File: rtl/dims_cgate_chk.sv
module dims_cgate_chk #(
    parameter int               K  = 3,
    parameter logic [(1<<K)-1:0] TT = 8'hE8
) (
    input logic         clk,
    input logic         rst,
    input logic [K-1:0] in_t,
    input logic [K-1:0] in_f,
    input logic         out_t,
    input logic         out_f,
    input logic         err
);
    logic all_valid, all_null, in_bad, out_null;
    assign all_valid = &(in_t ^ in_f);
    assign all_null  = ~|(in_t | in_f);
    assign in_bad    = |(in_t & in_f);
    assign out_null  = !out_t && !out_f;

    // R2
    reset_spacer_chk: assert property (@(posedge clk) rst |-> out_null);

    // R3
    early_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_null && $past(out_null) && !$past(in_bad)) |-> $past(all_valid));

    // R4
    set_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!out_null && $past(out_null) && $past(all_valid))
            |-> (out_t == TT[$past(in_t)]) && (out_f != out_t));

    // R6
    early_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_null && !$past(out_null) && !$past(in_bad)) |-> $past(all_null));

    // R7
    bad_input_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_bad |-> err);
endmodule

bind dims_cgate dims_cgate_chk #(.K(K), .TT(TT)) u_cgate_chk (
    .clk   (clk),
    .rst   (rst),
    .in_t  (in_t),
    .in_f  (in_f),
    .out_t (out_t),
    .out_f (out_f),
    .err   (err)
);

// File: tb/test_dims_cgate.sv
module test_dims_cgate;
    localparam int CLK_PERIOD = 10;
    localparam int K = 3;
    localparam logic [7:0] TT_A = 8'hB4;
    localparam logic [3:0] TT_B = 4'b1001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [K-1:0] in_t = '0, in_f = '0;
    logic out_t, out_f, err;
    logic o2_t, o2_f, err2;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dims_cgate #(.K(K), .TT(TT_A)) i_dims_cgate (
        .clk(clk), .rst(rst), .in_t(in_t), .in_f(in_f),
        .out_t(out_t), .out_f(out_f), .err(err)
    );

    dims_cgate #(.K(2), .TT(TT_B)) i_dims_cgate_k2 (
        .clk(clk), .rst(rst), .in_t(in_t[1:0]), .in_f(in_f[1:0]),
        .out_t(o2_t), .out_f(o2_f), .err(err2)
    );

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual {t,f,err}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // order 0 ascending, 1 descending
    function automatic int pos(int order, int n);
        return (order == 0) ? n : K - 1 - n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        // R2: reset state
        #1;
        check("R2 reset", {out_t, out_f, err}, 3'b000);
        step();
        step();
        @(negedge clk) rst = 1'b0;
        step();
        check("R2 after reset", {out_t, out_f, err}, 3'b000);

        for (int idx = 0; idx < 8; idx++) begin
            for (int order = 0; order < 2; order++) begin
                logic ev, ev2;
                ev  = TT_A[idx];
                ev2 = TT_B[idx[1:0]];
                for (int n = 0; n < K; n++) begin
                    int b;
                    b = pos(order, n);
                    @(negedge clk);
                    // R1: logic 1 is t=1,f=0; logic 0 is t=0,f=1
                    in_t[b] = idx[b];
                    in_f[b] = !idx[b];
                    step();
                    if (n < K - 1) begin
                        step();
                        // R3: partial inputs keep the spacer
                        check("R3 partial", {out_t, out_f, err}, 3'b000);
                    end
                end
                // R4 and R8: truth table value one edge after the last input
                check("R4 value", {out_t, out_f, err}, {ev, !ev, 1'b0});
                check("R8 second function", {o2_t, o2_f, err2}, {ev2, !ev2, 1'b0});
                for (int n = 0; n < K; n++) begin
                    int b;
                    b = pos(order, n);
                    @(negedge clk);
                    in_t[b] = 1'b0;
                    in_f[b] = 1'b0;
                    step();
                    if (n < K - 1) begin
                        step();
                        // R5: hold while some input is still valid
                        check("R5 hold", {out_t, out_f, err}, {ev, !ev, 1'b0});
                    end
                end
                // R6: spacer one edge after the last input resets
                check("R6 release", {out_t, out_f, err}, 3'b000);
                check("R6 second release", {o2_t, o2_f, err2}, 3'b000);
            end
        end

        // R7: forbidden input code flagged in the same cycle
        @(negedge clk);
        in_t = 3'b001;
        in_f = 3'b001;
        #1;
        check("R7 bad input", {1'b0, 1'b0, err}, 3'b001);
        // make the other inputs valid: indices 2 (0b010) and 3 (0b011) fire
        @(negedge clk);
        in_t = 3'b011;
        in_f = 3'b101;
        step();
        // TT_A[2]=1, TT_A[3]=0 so both output rails rise
        check("R7 bad output", {out_t, out_f, err}, 3'b111);

        // R2: asynchronous reset clears at once
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R2 async clear", {out_t, out_f, 1'b0}, 3'b000);
        in_t = '0;
        in_f = '0;
        #1;
        check("R7 flag clears", {1'b0, 1'b0, err}, 3'b000);
        step();
        @(negedge clk) rst = 1'b0;
        step();
        check("R2 idle after reset", {out_t, out_f, err}, 3'b000);

        report();
    end
endmodule